// File: doc/BRIEF.md
# Multi-Core Mailbox Interrupt Controller

A register-mapped mailbox unit through which several cores exchange short messages and interrupt each other. Each mailbox holds an owner mask, a receiver mask, a 2-bit mode field, an interrupt-enable mask, a 2-bit send code and a configurable number of 32-bit message words. A core takes a mailbox by writing its own bit into the owner mask, sets up the receiver, enables interrupts, loads the message and writes the send code for "message". The receiver sees its interrupt line rise, finds the mailbox through its masked status word, reads the message and writes the send code for "acknowledge", which moves the interrupt back to the owner. The owner then keeps the mailbox for the next message or releases it by writing zero to the owner mask.

All accesses arrive on a simple synchronous register bus that also carries the requesting core's index. Reads are combinational from the stored state; writes take effect at the clock edge. The mailbox count, core count and message-word count are parameters.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset every mailbox field, every message word, every status word and every interrupt output reads zero.
- R2: Address layout: bit 9 = 0 selects mailbox bits [8:4], word offset bits [3:0]: 0 owner, 1 receiver, 2 mode, 3 enable mask, 4 send, 8+k message word k. A nonzero owner write to a free mailbox (owner zero) stores the written core bits; a nonzero owner write to a taken mailbox is ignored.
- R3: An owner write of zero releases the mailbox and clears owner, receiver, mode, enable mask, send code and all message words in the next cycle.
- R4: While a mailbox is taken, writes to its receiver, enable mask and message words from a core whose bit is not in the owner mask are ignored.
- R5: Raw status of core c holds bit m when mailbox m has send code 01 and receiver bit c set, or send code 10 and owner bit c set.
- R6: Masked status of core c is its raw status with bit m kept only where mailbox m has enable bit c set; interrupt output c is high exactly when that masked status is nonzero.
- R7: Writing send code 00 clears both interrupt directions; code 11 is stored and read back as 00.
- R8: Bit 9 = 1 selects status: offset 0 raw and offset 1 masked status of core bits [8:4], offset 2 a configuration word with the mailbox count in bits [5:0] and the message-word count in bits [10:8]; message words beyond the configured count and status of nonexistent cores read zero and ignore writes.
- R9: The mode field stores and returns the two written bits from any core while the mailbox is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Register address |
| bus_core | input | 5 | Index of the requesting core |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq | output | NUM_CORE | One interrupt line per core |

## Verification
The assertions assume that each bus access carries a core index that matches the core driving it and that a mailbox is only released or re-sent through legal register writes; the bench always presents a defined address, core index and data when bus_sel is high and holds bus_sel low between accesses. They further assume that owner-mask writes carry only implemented core bits, which the bench keeps by writing one-hot masks built from indices below the core count. The sweep visits every mailbox with every ordered sender and receiver pair of a three-core, four-mailbox configuration.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W   = 10;
  localparam int IDX_W    = 5;
  localparam int BUS_W    = 32;

  localparam logic [3:0] OFF_OWN  = 4'd0;
  localparam logic [3:0] OFF_RCV  = 4'd1;
  localparam logic [3:0] OFF_MODE = 4'd2;
  localparam logic [3:0] OFF_ENA  = 4'd3;
  localparam logic [3:0] OFF_SEND = 4'd4;

  localparam logic [3:0] OFF_RAW  = 4'd0;
  localparam logic [3:0] OFF_MSKD = 4'd1;
  localparam logic [3:0] OFF_CFG  = 4'd2;

  typedef enum logic [1:0] {
    SEND_IDLE = 2'b00,
    SEND_MSG  = 2'b01,
    SEND_ACK  = 2'b10,
    SEND_RSV  = 2'b11
  } send_e;

  function automatic logic [1:0] norm_send(input logic [1:0] code);
    return (code == SEND_RSV) ? SEND_IDLE : code;
  endfunction

  function automatic logic raw_hit(input logic [1:0] code, input logic rcv_bit,
                                   input logic own_bit);
    return ((code == SEND_MSG) && rcv_bit) || ((code == SEND_ACK) && own_bit);
  endfunction

  function automatic logic bit_at(input logic [31:0] vec, input logic [IDX_W-1:0] idx);
    return vec[idx];
  endfunction

  function automatic logic [31:0] cfg_word(input int n_mbox, input int n_data);
    logic [5:0] nm;
    logic [2:0] nd;
    nm = 6'(n_mbox);
    nd = 3'(n_data);
    return {21'd0, nd, 2'd0, nm};
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NUM_MBOX = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              dec_stat,
  output logic [IDX_W-1:0]  dec_idx,
  output logic [3:0]        dec_off,
  output logic [NUM_MBOX-1:0] mbox_wr
);
  assign dec_stat = bus_addr[9];
  assign dec_idx  = bus_addr[8:4];
  assign dec_off  = bus_addr[3:0];

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_wr
    assign mbox_wr[m] = bus_sel && bus_wr && !dec_stat && (dec_idx == IDX_W'(m));
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int NUM_CORE = 4,
  parameter int NUM_DATA = 2,
  parameter int DATA_W   = 32,
  localparam int DSTORE  = (NUM_DATA == 0) ? 1 : NUM_DATA
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               wr_off,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [IDX_W-1:0]         req_core,
  output logic [NUM_CORE-1:0]      own_o,
  output logic [NUM_CORE-1:0]      rcv_o,
  output logic [NUM_CORE-1:0]      ena_o,
  output logic [1:0]               mode_o,
  output logic [1:0]               send_o,
  output logic [DSTORE*DATA_W-1:0] data_o,
  output logic                     ev_claim_o,
  output logic                     ev_claim_rej_o,
  output logic                     ev_release_o,
  output logic                     ev_blocked_o
);
  logic [NUM_CORE-1:0] own_q, rcv_q, ena_q;
  logic [1:0]          mode_q, send_q;
  logic [DATA_W-1:0]   data_q [DSTORE];

  logic is_free, is_owner, wr_own, wr_zero, may_edit, guarded_off;
  logic [2:0] word_idx;

  assign is_free     = (own_q == '0);
  assign is_owner    = bit_at(32'(own_q), req_core);
  assign wr_own      = wr_en && (wr_off == OFF_OWN);
  assign wr_zero     = (wdata[NUM_CORE-1:0] == '0);
  assign may_edit    = is_free || is_owner;
  assign word_idx    = wr_off[2:0];
  assign guarded_off = (wr_off == OFF_RCV) || (wr_off == OFF_ENA) || wr_off[3];

  assign ev_claim_o     = wr_own && is_free && !wr_zero;
  assign ev_claim_rej_o = wr_own && !is_free && !wr_zero;
  assign ev_release_o   = wr_own && wr_zero;
  assign ev_blocked_o   = wr_en && !may_edit && guarded_off;

  always_ff @(posedge clk) begin
    if (!rst_n || ev_release_o) begin
      own_q  <= '0;
      rcv_q  <= '0;
      ena_q  <= '0;
      mode_q <= '0;
      send_q <= '0;
    end else if (wr_en) begin
      if (ev_claim_o) own_q <= wdata[NUM_CORE-1:0];
      if (may_edit && (wr_off == OFF_RCV)) rcv_q <= wdata[NUM_CORE-1:0];
      if (may_edit && (wr_off == OFF_ENA)) ena_q <= wdata[NUM_CORE-1:0];
      if (wr_off == OFF_MODE) mode_q <= wdata[1:0];
      if (wr_off == OFF_SEND) send_q <= norm_send(wdata[1:0]);
    end
  end

  for (genvar d = 0; d < DSTORE; d++) begin : g_word
    if (d < NUM_DATA) begin : g_real
      always_ff @(posedge clk) begin
        if (!rst_n || ev_release_o) begin
          data_q[d] <= '0;
        end else if (wr_en && may_edit && wr_off[3] && (word_idx == 3'(d))) begin
          data_q[d] <= wdata;
        end
      end
    end else begin : g_none
      always_ff @(posedge clk) data_q[d] <= '0;
    end
    assign data_o[d*DATA_W +: DATA_W] = data_q[d];
  end

  assign own_o  = own_q;
  assign rcv_o  = rcv_q;
  assign ena_o  = ena_q;
  assign mode_o = mode_q;
  assign send_o = send_q;
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int NUM_CORE = 4
) (
  input  logic [2*NUM_MBOX-1:0]        send_flat,
  input  logic [NUM_MBOX*NUM_CORE-1:0] own_flat,
  input  logic [NUM_MBOX*NUM_CORE-1:0] rcv_flat,
  input  logic [NUM_MBOX*NUM_CORE-1:0] ena_flat,
  output logic [NUM_CORE*NUM_MBOX-1:0] raw_flat,
  output logic [NUM_CORE*NUM_MBOX-1:0] masked_flat,
  output logic [NUM_CORE-1:0]          irq_o
);
  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
      assign raw_flat[c*NUM_MBOX + m] = raw_hit(send_flat[2*m +: 2],
                                                rcv_flat[m*NUM_CORE + c],
                                                own_flat[m*NUM_CORE + c]);
      assign masked_flat[c*NUM_MBOX + m] = raw_flat[c*NUM_MBOX + m] &&
                                           ena_flat[m*NUM_CORE + c];
    end
    assign irq_o[c] = |masked_flat[c*NUM_MBOX +: NUM_MBOX];
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int NUM_CORE = 4,
  parameter int NUM_DATA = 2,
  localparam int DATA_W  = BUS_W,
  localparam int DSTORE  = (NUM_DATA == 0) ? 1 : NUM_DATA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [IDX_W-1:0]  bus_core,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CORE-1:0] irq
);
  logic                         dec_stat;
  logic [IDX_W-1:0]             dec_idx;
  logic [3:0]                   dec_off;
  logic [NUM_MBOX-1:0]          mbox_wr;
  logic [NUM_MBOX*NUM_CORE-1:0] own_flat, rcv_flat, ena_flat;
  logic [2*NUM_MBOX-1:0]        send_flat, mode_flat;
  logic [NUM_MBOX*DSTORE*DATA_W-1:0] data_flat;
  logic [NUM_CORE*NUM_MBOX-1:0] raw_flat, masked_flat;
  logic [NUM_MBOX-1:0]          ev_claim, ev_claim_rej, ev_release, ev_blocked;
  logic [BUS_W-1:0]             rd_val;

  mbx_decode #(.NUM_MBOX(NUM_MBOX)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .dec_stat(dec_stat), .dec_idx(dec_idx), .dec_off(dec_off), .mbox_wr(mbox_wr)
  );

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_slot
    mbx_slot #(.NUM_CORE(NUM_CORE), .NUM_DATA(NUM_DATA), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(mbox_wr[m]), .wr_off(dec_off),
      .wdata(bus_wdata), .req_core(bus_core),
      .own_o(own_flat[m*NUM_CORE +: NUM_CORE]),
      .rcv_o(rcv_flat[m*NUM_CORE +: NUM_CORE]),
      .ena_o(ena_flat[m*NUM_CORE +: NUM_CORE]),
      .mode_o(mode_flat[2*m +: 2]),
      .send_o(send_flat[2*m +: 2]),
      .data_o(data_flat[m*DSTORE*DATA_W +: DSTORE*DATA_W]),
      .ev_claim_o(ev_claim[m]), .ev_claim_rej_o(ev_claim_rej[m]),
      .ev_release_o(ev_release[m]), .ev_blocked_o(ev_blocked[m])
    );
  end

  mbx_status #(.NUM_MBOX(NUM_MBOX), .NUM_CORE(NUM_CORE)) u_stat (
    .send_flat(send_flat), .own_flat(own_flat), .rcv_flat(rcv_flat),
    .ena_flat(ena_flat), .raw_flat(raw_flat), .masked_flat(masked_flat),
    .irq_o(irq)
  );

  always_comb begin
    rd_val = '0;
    if (bus_sel && !bus_wr) begin
      if (dec_stat) begin
        if (dec_off == OFF_CFG) rd_val = cfg_word(NUM_MBOX, NUM_DATA);
        for (int c = 0; c < NUM_CORE; c++) begin
          if (dec_idx == IDX_W'(c)) begin
            if (dec_off == OFF_RAW)
              rd_val[NUM_MBOX-1:0] = raw_flat[c*NUM_MBOX +: NUM_MBOX];
            if (dec_off == OFF_MSKD)
              rd_val[NUM_MBOX-1:0] = masked_flat[c*NUM_MBOX +: NUM_MBOX];
          end
        end
      end else begin
        for (int m = 0; m < NUM_MBOX; m++) begin
          if (dec_idx == IDX_W'(m)) begin
            case (dec_off)
              OFF_OWN:  rd_val[NUM_CORE-1:0] = own_flat[m*NUM_CORE +: NUM_CORE];
              OFF_RCV:  rd_val[NUM_CORE-1:0] = rcv_flat[m*NUM_CORE +: NUM_CORE];
              OFF_ENA:  rd_val[NUM_CORE-1:0] = ena_flat[m*NUM_CORE +: NUM_CORE];
              OFF_MODE: rd_val[1:0] = mode_flat[2*m +: 2];
              OFF_SEND: rd_val[1:0] = send_flat[2*m +: 2];
              default: begin
                for (int d = 0; d < NUM_DATA; d++) begin
                  if (dec_off == 4'(8 + d))
                    rd_val = data_flat[(m*DSTORE + d)*DATA_W +: DATA_W];
                end
              end
            endcase
          end
        end
      end
    end
  end

  assign bus_rdata = rd_val;
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk #(
  parameter int NUM_MBOX = 4,
  parameter int NUM_CORE = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CORE-1:0]          irq,
  input logic [NUM_MBOX*NUM_CORE-1:0] own_flat,
  input logic [NUM_MBOX*NUM_CORE-1:0] rcv_flat,
  input logic [NUM_MBOX*NUM_CORE-1:0] ena_flat,
  input logic [2*NUM_MBOX-1:0]        send_flat,
  input logic [NUM_MBOX-1:0]          ev_claim_rej,
  input logic [NUM_MBOX-1:0]          ev_release,
  input logic [NUM_MBOX-1:0]          ev_blocked
);
  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_m
    p_taken_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_claim_rej[m] |=> $stable(own_flat[m*NUM_CORE +: NUM_CORE]));

    p_release_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_release[m] |=> (own_flat[m*NUM_CORE +: NUM_CORE] == '0) &&
                        (rcv_flat[m*NUM_CORE +: NUM_CORE] == '0) &&
                        (ena_flat[m*NUM_CORE +: NUM_CORE] == '0) &&
                        (send_flat[2*m +: 2] == 2'b00));

    p_foreign_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_blocked[m] |=> $stable(rcv_flat[m*NUM_CORE +: NUM_CORE]) &&
                        $stable(ena_flat[m*NUM_CORE +: NUM_CORE]));

    p_no_reserved_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
      send_flat[2*m +: 2] != 2'b11);
  end

  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_flat == '0) |-> (irq == '0));

  p_irq_needs_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (send_flat == '0) |-> (irq == '0));
endmodule

bind mbx_ctrl mbx_ctrl_chk #(.NUM_MBOX(NUM_MBOX), .NUM_CORE(NUM_CORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .own_flat(own_flat), .rcv_flat(rcv_flat),
  .ena_flat(ena_flat), .send_flat(send_flat), .ev_claim_rej(ev_claim_rej),
  .ev_release(ev_release), .ev_blocked(ev_blocked)
);

// File: tb/test_mbx_ctrl.sv
module test_mbx_ctrl;
  localparam int NM = 4;
  localparam int NC = 3;
  localparam int ND = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [4:0]  bus_core = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_ctrl #(.NUM_MBOX(NM), .NUM_CORE(NC), .NUM_DATA(ND)) i_mbx_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_core(bus_core), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [9:0] ma(input int m, input int off);
    return {1'b0, 5'(m), 4'(off)};
  endfunction
  function automatic logic [9:0] sa(input int c, input int off);
    return {1'b1, 5'(c), 4'(off)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int c, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_core = 5'(c); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int c, input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_core = 5'(c); bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(0, a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    for (int m = 0; m < NM; m++) begin
      for (int off = 0; off < 5; off++) rchk("R1 field", ma(m, off), 0);
      for (int d = 0; d < ND; d++) rchk("R1 word", ma(m, 8 + d), 0);
    end
    for (int c = 0; c < NC; c++) begin
      rchk("R1 raw", sa(c, 0), 0);
      rchk("R1 masked", sa(c, 1), 0);
    end
    // R8: configuration word
    rchk("R8 cfg", sa(0, 2), NM | (ND << 8));

    // Sweep every mailbox with every ordered sender/receiver pair
    for (int m = 0; m < NM; m++) begin
      for (int s = 0; s < NC; s++) begin
        for (int r = 0; r < NC; r++) begin
          if (r == s) continue;
          p = 32'hA500_0000 | (m << 8) | (s << 4) | r;
          wr(s, ma(m, 0), 1 << s);
          rchk("R2 claim", ma(m, 0), 1 << s);
          wr(r, ma(m, 0), 1 << r);
          rchk("R2 taken ignored", ma(m, 0), 1 << s);
          wr(r, ma(m, 1), 1 << s);
          rchk("R4 foreign receiver", ma(m, 1), 0);
          wr(s, ma(m, 1), 1 << r);
          wr(s, ma(m, 3), 7);
          wr(s, ma(m, 8), p);
          wr(s, ma(m, 9), ~p);
          wr(r, ma(m, 8), 0);
          wr(r, ma(m, 3), 0);
          rchk("R4 foreign word", ma(m, 8), p);
          rchk("R4 foreign mask", ma(m, 3), 7);
          rchk("R4 owner word1", ma(m, 9), ~p);
          wr(r, ma(m, 2), (m + s) & 3);
          rchk("R9 mode", ma(m, 2), (m + s) & 3);
          wr(s, ma(m, 4), 1);
          chk("R6 irq msg", 32'(irq), 1 << r);
          rchk("R5 raw rcv", sa(r, 0), 1 << m);
          rchk("R6 masked rcv", sa(r, 1), 1 << m);
          rchk("R5 raw owner idle", sa(s, 0), 0);
          wr(r, ma(m, 4), 2);
          chk("R6 irq ack", 32'(irq), 1 << s);
          rchk("R5 raw owner ack", sa(s, 0), 1 << m);
          rchk("R5 raw rcv cleared", sa(r, 0), 0);
          wr(s, ma(m, 0), 0);
          rchk("R3 owner", ma(m, 0), 0);
          rchk("R3 receiver", ma(m, 1), 0);
          rchk("R3 mode", ma(m, 2), 0);
          rchk("R3 mask", ma(m, 3), 0);
          rchk("R3 send", ma(m, 4), 0);
          rchk("R3 word0", ma(m, 8), 0);
          rchk("R3 word1", ma(m, 9), 0);
          chk("R3 irq", 32'(irq), 0);
        end
      end
    end

    // R6: partial enable mask
    wr(0, ma(1, 0), 1);
    wr(0, ma(1, 1), 3'b110);
    wr(0, ma(1, 3), 3'b010);
    wr(0, ma(1, 4), 1);
    rchk("R5 raw core2", sa(2, 0), 1 << 1);
    rchk("R6 masked core2", sa(2, 1), 0);
    rchk("R6 masked core1", sa(1, 1), 1 << 1);
    chk("R6 irq partial", 32'(irq), 3'b010);
    // R7: reserved and idle codes
    wr(0, ma(1, 4), 3);
    rchk("R7 reserved reads 00", ma(1, 4), 0);
    chk("R7 reserved irq", 32'(irq), 0);
    wr(0, ma(1, 4), 1);
    chk("R7 resend irq", 32'(irq), 3'b010);
    wr(0, ma(1, 4), 0);
    chk("R7 idle irq", 32'(irq), 0);
    // R6: two mailboxes active together
    wr(0, ma(1, 4), 1);
    wr(1, ma(2, 0), 2);
    wr(1, ma(2, 1), 3'b100);
    wr(1, ma(2, 3), 3'b111);
    wr(1, ma(2, 4), 1);
    rchk("R5 raw two boxes", sa(2, 0), (1 << 1) | (1 << 2));
    rchk("R6 masked two boxes", sa(2, 1), 1 << 2);
    chk("R6 irq two boxes", 32'(irq), 3'b110);

    // R8: unimplemented word and nonexistent core
    wr(1, ma(2, 10), 32'hDEAD_BEEF);
    rchk("R8 missing word", ma(2, 10), 0);
    rchk("R8 missing core", sa(3, 0), 0);
    rchk("R8 word0 untouched", ma(2, 8), 0);

    wr(0, ma(1, 0), 0);
    wr(1, ma(2, 0), 0);
    chk("R3 all released irq", 32'(irq), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule